// File: doc/BRIEF.md
# Banked GPIO Register Front End

This block is the register side of a 128-line general-purpose I/O port, organised as four banks of 32 pins. A simple synchronous bus reaches it with read and write strobes, a byte address, and 32-bit data. Each bank has the following registers:

- direction
- output set and output clear strobes
- rising-edge and falling-edge enable words
- two alternate-function words
- a pin-level view
- an edge-status view

The block holds the output latches and the direction bits. It drives the pads from them and exports the enable and alternate-function words to neighbouring logic.

Edge detection itself lives in a separate block. Reads of an edge-status register return that block's status vector. A write to an edge-status register is passed to it as a one-cycle clear mask. Every read of a pin-level register also emits a one-cycle notify pulse, so that a model of external hardware can react to the software poll.

The map is deliberately uneven, and the offsets matter to software:

- The first three banks of each register group sit on consecutive words.
- The fourth bank of each group lives 0x100 higher.
- The two alternate-function words of each bank are interleaved.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is asserted and right after it, the output latches, direction bits, edge enables and alternate-function words are zero, so all pins are inputs. The pads, pad enables, read data, notify pulse and clear mask are all zero.
- R2: The register groups have the following base byte offsets: pin level 0x000, direction 0x00C, set 0x018, clear 0x024, rising enable 0x030, falling enable 0x03C, edge status 0x048. Banks 0, 1 and 2 sit at base+4·bank, and bank 3 sits at base+0x100. Direction words read back what was written.
- R3: Alternate-function low words are at 0x054+8·bank and high words at 0x058+8·bank. They read back what was written and appear on `alt_fn_o`: bank b low at bits [64b+31:64b], high at [64b+63:64b+32].
- R4: A write to a bank's set register ORs the written value into that bank's output latch.
- R5: A write to a bank's clear register clears each latch bit where the written value holds a 1, and leaves the other bits unchanged.
- R6: Reads of set and clear registers return zero.
- R7: A pin-level read returns, per pin, the latch bit where the direction bit is 1 (output) and the `pin_in_i` bit sampled in the strobe cycle where the direction bit is 0 (input).
- R8: Every pin-level read makes `level_rd_pulse_o` high for exactly the cycle in which its read data is presented. Reads of other registers never raise it.
- R9: Addresses at or above 0x200, addresses whose low two bits are not zero, and unmapped word offsets read as zero. Writes to them change no register.
- R10: `pad_oe_o` equals the direction bits and `pad_out_o` equals latch AND direction. Both follow a register write from the cycle after the write strobe.
- R11: Read data is registered. It is valid in the cycle after the read strobe and zero in any cycle that does not follow a read strobe.
- R12: An edge-status read returns that bank's slice of `edge_status_i` sampled in the strobe cycle. An edge-status write drives the written value onto that bank's 32-bit slice of `edge_clr_o` for the one cycle after the strobe, with all other bits zero.
- R13: Rising and falling enable words read back what was written and appear on `rise_en_o` and `fall_en_o`, with bank b at bits [32b+31:32b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 12 | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | 128 | Sampled pad input levels |
| edge_status_i | input | 128 | Edge status from the edge-detect block |
| pad_out_o | output | 128 | Pad output values |
| pad_oe_o | output | 128 | Pad output enables |
| rise_en_o | output | 128 | Rising-edge enables per pin |
| fall_en_o | output | 128 | Falling-edge enables per pin |
| alt_fn_o | output | 256 | Alternate-function words, two per bank |
| edge_clr_o | output | 128 | One-cycle edge-status clear mask |
| level_rd_pulse_o | output | 1 | Notify pulse for pin-level reads |

## Verification
A directed phase exercises the following patterns:

- It mixes direction masks per bank and then overlaps set and clear patterns. A pin-level read therefore separates latch bits from input bits, and a wrong merge or a swapped set/clear is exposed.
- Each bank-3 offset and each interleaved alternate-function word is written with a distinct value. This catches any decode that folds bank 3 onto bank 0 or swaps low and high words.
- Misaligned, out-of-window and gap addresses are written with all ones. The writes must leave every exported register untouched.

A long random phase then mixes accesses, pin inputs and status inputs. A behavioural model compares every output on every cycle.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    localparam int NUM_BANKS    = 4;
    localparam int BANK_W       = 32;
    localparam int LINES        = NUM_BANKS * BANK_W;
    localparam int BANK_IDX_W   = $clog2(NUM_BANKS);
    localparam int N_GROUPS     = 7;
    localparam int GROUP_STRIDE = 12;
    localparam int WINDOW_BYTES = 32'h200;
    localparam int HI_BANK_OFS  = 32'h100;
    localparam int ALT_BASE     = 32'h054;
    localparam int ALT_STRIDE   = 8;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_LEVEL,
        RK_DIR,
        RK_SET,
        RK_CLR,
        RK_RISE,
        RK_FALL,
        RK_EDGE,
        RK_ALT_LO,
        RK_ALT_HI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e               kind;
        logic [BANK_IDX_W-1:0]   bank;
    } reg_sel_t;

    typedef struct packed {
        logic [BANK_W-1:0] latch;
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] rise;
        logic [BANK_W-1:0] fall;
        logic [BANK_W-1:0] alt_lo;
        logic [BANK_W-1:0] alt_hi;
    } bank_state_t;

    // Group order follows the address map: group g sits at g*GROUP_STRIDE.
    function automatic reg_kind_e kind_of_group(input int g);
        case (g)
            0:       return RK_LEVEL;
            1:       return RK_DIR;
            2:       return RK_SET;
            3:       return RK_CLR;
            4:       return RK_RISE;
            5:       return RK_FALL;
            6:       return RK_EDGE;
            default: return RK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);

    logic [31:0] addr_ext;
    assign addr_ext = 32'(addr_i);

    always_comb begin
        sel_o.kind = RK_NONE;
        sel_o.bank = '0;
        if (addr_ext < 32'(WINDOW_BYTES) && addr_ext[1:0] == 2'b00) begin
            // Plain groups: low banks packed, the top bank lifted by HI_BANK_OFS.
            for (int g = 0; g < N_GROUPS; g++) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (b == NUM_BANKS - 1) begin
                        if (addr_ext == 32'(HI_BANK_OFS + g * GROUP_STRIDE)) begin
                            sel_o.kind = kind_of_group(g);
                            sel_o.bank = BANK_IDX_W'(b);
                        end
                    end else begin
                        if (addr_ext == 32'(g * GROUP_STRIDE + b * 4)) begin
                            sel_o.kind = kind_of_group(g);
                            sel_o.bank = BANK_IDX_W'(b);
                        end
                    end
                end
            end
            // Alternate-function words interleave low/high per bank.
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (addr_ext == 32'(ALT_BASE + b * ALT_STRIDE)) begin
                    sel_o.kind = RK_ALT_LO;
                    sel_o.bank = BANK_IDX_W'(b);
                end
                if (addr_ext == 32'(ALT_BASE + b * ALT_STRIDE + 4)) begin
                    sel_o.kind = RK_ALT_HI;
                    sel_o.bank = BANK_IDX_W'(b);
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
    import gpio_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  reg_kind_e         kind_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] latch_o,
    output logic [BANK_W-1:0] dir_o,
    output logic [BANK_W-1:0] rise_o,
    output logic [BANK_W-1:0] fall_o,
    output logic [BANK_W-1:0] alt_lo_o,
    output logic [BANK_W-1:0] alt_hi_o
);

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (kind_i)
                RK_DIR:    st_d.dir    = wdata_i;
                RK_SET:    st_d.latch  = st_q.latch | wdata_i;
                RK_CLR:    st_d.latch  = st_q.latch & ~wdata_i;
                RK_RISE:   st_d.rise   = wdata_i;
                RK_FALL:   st_d.fall   = wdata_i;
                RK_ALT_LO: st_d.alt_lo = wdata_i;
                RK_ALT_HI: st_d.alt_hi = wdata_i;
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o  = st_q.latch;
    assign dir_o    = st_q.dir;
    assign rise_o   = st_q.rise;
    assign fall_o   = st_q.fall;
    assign alt_lo_o = st_q.alt_lo;
    assign alt_hi_o = st_q.alt_hi;

    assert_set_ors_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_SET) |=> ((latch_o & $past(wdata_i)) == $past(wdata_i)));

    assert_clr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_CLR) |=> ((latch_o & $past(wdata_i)) == '0));

    assert_clr_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_CLR) |=> ((latch_o & ~$past(wdata_i)) == ($past(latch_o) & ~$past(wdata_i))));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(latch_o) && $stable(dir_o)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_rd_i,
    input  logic                    bus_wr_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [BANK_W-1:0]       bus_wdata_i,
    output logic [BANK_W-1:0]       bus_rdata_o,
    input  logic [LINES-1:0]        pin_in_i,
    input  logic [LINES-1:0]        edge_status_i,
    output logic [LINES-1:0]        pad_out_o,
    output logic [LINES-1:0]        pad_oe_o,
    output logic [LINES-1:0]        rise_en_o,
    output logic [LINES-1:0]        fall_en_o,
    output logic [2*LINES-1:0]      alt_fn_o,
    output logic [LINES-1:0]        edge_clr_o,
    output logic                    level_rd_pulse_o
);

    typedef struct packed {
        logic [BANK_W-1:0] rdata;
        logic              notify;
        logic [LINES-1:0]  clr;
    } front_state_t;

    reg_sel_t sel;

    logic [NUM_BANKS-1:0][BANK_W-1:0] latch_w, dir_w, rise_w, fall_w, alo_w, ahi_w;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_wr_i && (sel.bank == BANK_IDX_W'(b));

        gpio_bank_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (bank_wr),
            .kind_i   (sel.kind),
            .wdata_i  (bus_wdata_i),
            .latch_o  (latch_w[b]),
            .dir_o    (dir_w[b]),
            .rise_o   (rise_w[b]),
            .fall_o   (fall_w[b]),
            .alt_lo_o (alo_w[b]),
            .alt_hi_o (ahi_w[b])
        );

        assign pad_out_o[b*BANK_W +: BANK_W]        = latch_w[b] & dir_w[b];
        assign pad_oe_o[b*BANK_W +: BANK_W]         = dir_w[b];
        assign rise_en_o[b*BANK_W +: BANK_W]        = rise_w[b];
        assign fall_en_o[b*BANK_W +: BANK_W]        = fall_w[b];
        assign alt_fn_o[2*b*BANK_W +: BANK_W]       = alo_w[b];
        assign alt_fn_o[(2*b+1)*BANK_W +: BANK_W]   = ahi_w[b];
    end

    front_state_t fs_d, fs_q;
    logic [BANK_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel.bank == BANK_IDX_W'(b)) begin
                case (sel.kind)
                    RK_LEVEL:  rd_word = (latch_w[b] & dir_w[b]) |
                                         (pin_in_i[b*BANK_W +: BANK_W] & ~dir_w[b]);
                    RK_DIR:    rd_word = dir_w[b];
                    RK_RISE:   rd_word = rise_w[b];
                    RK_FALL:   rd_word = fall_w[b];
                    RK_EDGE:   rd_word = edge_status_i[b*BANK_W +: BANK_W];
                    RK_ALT_LO: rd_word = alo_w[b];
                    RK_ALT_HI: rd_word = ahi_w[b];
                    default:   rd_word = '0;
                endcase
            end
        end
    end

    always_comb begin
        fs_d        = '0;
        fs_d.rdata  = bus_rd_i ? rd_word : '0;
        fs_d.notify = bus_rd_i && (sel.kind == RK_LEVEL);
        if (bus_wr_i && sel.kind == RK_EDGE) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (sel.bank == BANK_IDX_W'(b)) fs_d.clr[b*BANK_W +: BANK_W] = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign bus_rdata_o      = fs_q.rdata;
    assign level_rd_pulse_o = fs_q.notify;
    assign edge_clr_o       = fs_q.clr;

    assert_rdata_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> (bus_rdata_o == '0));

    assert_notify_on_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && sel.kind == RK_LEVEL) |=> level_rd_pulse_o);

    assert_no_notify_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> !level_rd_pulse_o);

    assert_wo_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && (sel.kind == RK_SET || sel.kind == RK_CLR)) |=> (bus_rdata_o == '0));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && sel.kind == RK_NONE) |=> ($stable(pad_out_o) && $stable(pad_oe_o) &&
                                               $stable(alt_fn_o) && (edge_clr_o == '0)));

    assert_clr_single_bank_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_i |=> (edge_clr_o == '0));

endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [127:0]  pin_in = '0, edge_st = '0;
    logic [31:0]   rdata;
    logic [127:0]  pad_out, pad_oe, rise_en, fall_en, edge_clr;
    logic [255:0]  alt_fn;
    logic          notify;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    gpio_bank_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pin_in_i(pin_in), .edge_status_i(edge_st),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .rise_en_o(rise_en),
        .fall_en_o(fall_en), .alt_fn_o(alt_fn), .edge_clr_o(edge_clr),
        .level_rd_pulse_o(notify)
    );

    // Behavioural model state
    logic [31:0] m_lat[4], m_dir[4], m_rise[4], m_fall[4], m_alo[4], m_ahi[4];
    logic [31:0] e_rdata;
    logic        e_notify;
    logic [127:0] e_clr;
    string       rtag = "R1", ptag = "R1";

    // kind codes: 0 none 1 level 2 dir 3 set 4 clr 5 rise 6 fall 7 edge 8 alt-lo 9 alt-hi
    function automatic void mdecode(input int unsigned a, output int kind, output int bank);
        int unsigned o, k;
        kind = 0; bank = 0;
        if (a >= 512 || a % 4 != 0) return;
        if (a >= 256) begin
            o = a - 256;
            if (o % 12 == 0 && o / 12 < 7) begin kind = o / 12 + 1; bank = 3; end
        end else if (a < 84) begin
            kind = a / 12 + 1; bank = (a % 12) / 4;
        end else if (a <= 112) begin
            k = (a - 84) / 4; bank = k / 2; kind = 8 + k % 2;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int kind, bank;
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                m_lat[b] = 0; m_dir[b] = 0; m_rise[b] = 0; m_fall[b] = 0; m_alo[b] = 0; m_ahi[b] = 0;
            end
            e_rdata = 0; e_notify = 0; e_clr = 0; rtag = "R1"; ptag = "R1";
        end else begin
            e_rdata = 0; e_notify = 0; e_clr = 0; rtag = "R11";
            mdecode(32'(addr), kind, bank);
            if (rd) begin
                case (kind)
                    1: begin e_rdata = (m_lat[bank] & m_dir[bank]) | (pin_in[bank*32 +: 32] & ~m_dir[bank]);
                             e_notify = 1; rtag = "R7"; end
                    2: begin e_rdata = m_dir[bank]; rtag = "R2"; end
                    3, 4: rtag = "R6";
                    5: begin e_rdata = m_rise[bank]; rtag = "R13"; end
                    6: begin e_rdata = m_fall[bank]; rtag = "R13"; end
                    7: begin e_rdata = edge_st[bank*32 +: 32]; rtag = "R12"; end
                    8: begin e_rdata = m_alo[bank]; rtag = "R3"; end
                    9: begin e_rdata = m_ahi[bank]; rtag = "R3"; end
                    default: rtag = "R9";
                endcase
            end
            if (wr) begin
                ptag = "R10";
                case (kind)
                    2: m_dir[bank] = wdata;
                    3: begin m_lat[bank] = m_lat[bank] | wdata; ptag = "R4"; end
                    4: begin m_lat[bank] = m_lat[bank] & ~wdata; ptag = "R5"; end
                    5: m_rise[bank] = wdata;
                    6: m_fall[bank] = wdata;
                    7: e_clr[bank*32 +: 32] = wdata;
                    8: m_alo[bank] = wdata;
                    9: m_ahi[bank] = wdata;
                    default: ptag = (kind == 0) ? "R9" : "R10";
                endcase
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [127:0] e_po, e_oe, e_re, e_fe;
        logic [255:0] e_af;
        for (int b = 0; b < 4; b++) begin
            e_po[b*32 +: 32] = m_lat[b] & m_dir[b];
            e_oe[b*32 +: 32] = m_dir[b];
            e_re[b*32 +: 32] = m_rise[b];
            e_fe[b*32 +: 32] = m_fall[b];
            e_af[64*b +: 32] = m_alo[b];
            e_af[64*b+32 +: 32] = m_ahi[b];
        end
        chk(rtag, "rdata", 256'(rdata), 256'(e_rdata));
        chk("R8", "notify", 256'(notify), 256'(e_notify));
        chk("R12", "edge_clr", 256'(edge_clr), 256'(e_clr));
        chk(ptag, "pad_out", 256'(pad_out), 256'(e_po));
        chk(ptag, "pad_oe", 256'(pad_oe), 256'(e_oe));
        chk("R13", "rise_en", 256'(rise_en), 256'(e_re));
        chk("R13", "fall_en", 256'(fall_en), 256'(e_fe));
        chk("R3", "alt_fn", alt_fn, e_af);
    end

    task automatic bus_op(input logic r, input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d;
        pin_in = {$urandom, $urandom, $urandom, $urandom};
        edge_st = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        rd = 0; wr = 0;
    endtask

    task automatic wr_op(input logic [11:0] a, input logic [31:0] d); bus_op(0, 1, a, d); endtask
    task automatic rd_op(input logic [11:0] a); bus_op(1, 0, a, 0); endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [11:0] grp_addr(input int g, input int b);
        return (b == 3) ? 12'(256 + 12 * g) : 12'(12 * g + 4 * b);
    endfunction

    initial begin
        repeat (3) @(negedge clk);        // R1: checks run while reset held
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R10 direction per bank, R4 set, R5 clear, R7 level read
        for (int b = 0; b < 4; b++) begin
            wr_op(grp_addr(1, b), 32'hFFFF0000 ^ (32'h1111 << b));
            wr_op(grp_addr(2, b), 32'hF0F0F0F0);
            wr_op(grp_addr(3, b), 32'h30300303);
            rd_op(grp_addr(0, b));
            rd_op(grp_addr(1, b));
            rd_op(grp_addr(2, b));        // R6
            rd_op(grp_addr(3, b));        // R6
            wr_op(grp_addr(4, b), 32'hA5000000 + b);
            wr_op(grp_addr(5, b), 32'h5A000000 + b);
            rd_op(grp_addr(4, b));
            rd_op(grp_addr(5, b));
            wr_op(grp_addr(6, b), 32'h0000C0DE + b);   // R12 clear mask
            rd_op(grp_addr(6, b));                     // R12 status read
            wr_op(12'(84 + 8 * b), 32'h10000000 + b);  // R3
            wr_op(12'(88 + 8 * b), 32'h20000000 + b);
            rd_op(12'(84 + 8 * b));
            rd_op(12'(88 + 8 * b));
        end
        // R9 gaps, window overflow, misalignment
        foreach (pin_in[i]) if (i < 8) begin
            logic [11:0] bad;
            case (i)
                0: bad = 12'h074; 1: bad = 12'h1FC; 2: bad = 12'h200; 3: bad = 12'h30C;
                4: bad = 12'h001; 5: bad = 12'h10E; 6: bad = 12'h14C; default: bad = 12'hFFC;
            endcase
            wr_op(bad, 32'hFFFFFFFF);
            rd_op(bad);
        end
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            a = 12'($urandom % 32'h220);
            if ($urandom % 10 != 0) a[1:0] = 2'b00;
            case ($urandom % 3)
                0: rd_op(a);
                1: wr_op(a, $urandom);
                default: bus_op(0, 0, a, $urandom);
            endcase
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule